// File: doc/BRIEF.md
# Arm Submodule Insertion Selector with Current Balancing

This block chooses which of the parallel inductor submodules of one converter arm carry the arm current. A modulator outside the block supplies how many submodules must be inserted. Because the arm output depends only on that number, the block is free to choose which ones. It uses that freedom to keep the inductor currents equal. An inserted inductor charges while the arm voltage is positive and discharges while it is negative. So with positive voltage the block prefers the submodules with the least current, and with negative voltage the ones with the most.

Every pair of submodule currents is compared in a registered matrix stage. A second registered stage updates the insertion set. The set changes only by the difference between the new and the present count: extra submodules are added from the bypassed ones that rank best, and surplus ones are removed from the inserted ones that rank worst. If the count does not change, the set is held and no switching happens. A faulted submodule is forced out of the set, and a healthy spare takes its place. A request larger than the number of healthy submodules is clamped, and an error flag is raised.

Top module: `sm_balance_top`

## Requirements
- R1: After reset every submodule is bypassed: gate_hi is all zeros, gate_lo is all ones and clamp_err is 0.
- R2: Two clock edges after the inputs are applied, the number of set bits in gate_hi equals the requested count, clamped to the number of healthy submodules.
- R3: When the count rises, every submodule already inserted stays inserted. With arm_vpos=1 the added ones are the bypassed healthy submodules with the lowest currents.
- R4: With arm_vpos=0 the added submodules are the bypassed healthy ones with the highest currents.
- R5: When the count falls, only inserted submodules are bypassed, taking the worst-ranked first. That is the highest current when arm_vpos=1 and the lowest current when arm_vpos=0.
- R6: While the count and the fault flags stay unchanged, the selection is held, even if the currents or the polarity change.
- R7: Equal currents rank by index: the lower index is inserted first and bypassed last.
- R8: A submodule whose bit in sm_fault is 1 is bypassed. A healthy bypassed submodule, picked by rank, is inserted so that the count is kept.
- R9: A request above the healthy count inserts every healthy submodule and sets clamp_err to 1, with the same latency as the gates. clamp_err is 0 otherwise.
- R10: For every submodule, gate_lo is the complement of gate_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cnt | input | CNT_W | Number of submodules to insert |
| sm_cur | input | NUM_SM*CUR_W | Unsigned inductor currents; submodule i occupies bits [i*CUR_W +: CUR_W] |
| arm_vpos | input | 1 | 1 when the arm voltage is positive |
| sm_fault | input | NUM_SM | Per-submodule fault flag, bit i for submodule i |
| gate_hi | output | NUM_SM | Upper switch command; 1 means inserted |
| gate_lo | output | NUM_SM | Lower switch command; 1 means bypassed |
| clamp_err | output | 1 | Request exceeded the healthy count |

## Verification
Each gate and error result is due exactly two rising edges after its inputs: one edge for the comparator matrix and one for the selection update. The driver applies a stimulus just after a falling edge and records the cycle number at which the result is due. The monitor compares at the falling edge of that cycle, so the outputs are already settled. Inputs are held until that check has been made. The steps chain count rises, count falls, polarity changes, ties, a fault and a clamp. The expected sets are worked out by hand from the ranking rules.

// File: rtl/sm_balance_pkg.sv
package sm_balance_pkg;

   typedef enum logic {
      POL_NEG = 1'b0,
      POL_POS = 1'b1
   } arm_pol_e;

   // Returns 1 when candidate (cand_cur, cand_idx) should be inserted ahead
   // of reference (ref_cur, ref_idx) for the given arm polarity.
   function automatic logic ranks_ahead(input logic [31:0] cand_cur,
                                        input int          cand_idx,
                                        input logic [31:0] ref_cur,
                                        input int          ref_idx,
                                        input arm_pol_e    pol);
      logic tie_win;
      tie_win = (cand_cur == ref_cur) && (cand_idx < ref_idx);
      if (pol == POL_POS) return (cand_cur < ref_cur) || tie_win;
      else                return (cand_cur > ref_cur) || tie_win;
   endfunction

endpackage

// File: rtl/sm_rank_stage.sv
module sm_rank_stage
   import sm_balance_pkg::*;
#(
   parameter int NUM_SM = 8,
   parameter int CUR_W  = 12,
   parameter int CNT_W  = $clog2(NUM_SM + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CNT_W-1:0]              req_cnt,
   input  logic [NUM_SM*CUR_W-1:0]       sm_cur,
   input  logic                          arm_vpos,
   input  logic [NUM_SM-1:0]             sm_fault,
   output logic [NUM_SM-1:0][NUM_SM-1:0] ahead_q,
   output logic [CNT_W-1:0]              cnt_q,
   output logic [NUM_SM-1:0]             fault_q,
   output logic                          err_q
);

   logic [NUM_SM-1:0][NUM_SM-1:0] ahead_d;
   logic [CNT_W-1:0]              healthy;
   logic                          over;
   arm_pol_e                      pol;

   assign pol = arm_pol_e'(arm_vpos);

   // ahead_d[i][j] = 1 when submodule j ranks ahead of submodule i
   for (genvar i = 0; i < NUM_SM; i++) begin : g_row
      for (genvar j = 0; j < NUM_SM; j++) begin : g_col
         if (i == j) begin : g_diag
            assign ahead_d[i][j] = 1'b0;
         end else begin : g_cmp
            assign ahead_d[i][j] = ranks_ahead(32'(sm_cur[j*CUR_W +: CUR_W]), j,
                                               32'(sm_cur[i*CUR_W +: CUR_W]), i,
                                               pol);
         end
      end
   end

   assign healthy = CNT_W'($countones(~sm_fault));
   assign over    = (req_cnt > healthy);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ahead_q <= '0;
         cnt_q   <= '0;
         fault_q <= '0;
         err_q   <= 1'b0;
      end else begin
         ahead_q <= ahead_d;
         cnt_q   <= over ? healthy : req_cnt;
         fault_q <= sm_fault;
         err_q   <= over;
      end
   end

   // R9: a flagged request is clamped to exactly the healthy count
   a_r9_clamp_to_healthy: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (CNT_W'($countones(~fault_q)) == cnt_q));

endmodule

// File: rtl/sm_select_stage.sv
module sm_select_stage #(
   parameter int NUM_SM = 8,
   parameter int CNT_W  = $clog2(NUM_SM + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SM-1:0][NUM_SM-1:0] ahead_q,
   input  logic [CNT_W-1:0]              cnt_q,
   input  logic [NUM_SM-1:0]             fault_q,
   input  logic                          err_q,
   output logic [NUM_SM-1:0]             ins_q,
   output logic                          err_o
);

   logic [NUM_SM-1:0][NUM_SM-1:0] behind;
   logic [NUM_SM-1:0]             live_ins, cand_add, add_sel, drop_sel, ins_d;
   logic [CNT_W-1:0]              live_cnt, need_add, need_drop;
   logic [CNT_W-1:0]              rank_add [NUM_SM];
   logic [CNT_W-1:0]              rank_drop [NUM_SM];

   // behind[i][j] = 1 when submodule i ranks ahead of j (j is worse than i)
   for (genvar i = 0; i < NUM_SM; i++) begin : g_tr
      for (genvar j = 0; j < NUM_SM; j++) begin : g_tc
         assign behind[i][j] = ahead_q[j][i];
      end
   end

   always_comb begin
      live_ins  = ins_q & ~fault_q;
      cand_add  = ~ins_q & ~fault_q;
      live_cnt  = CNT_W'($countones(live_ins));
      need_add  = (cnt_q > live_cnt) ? (cnt_q - live_cnt) : '0;
      need_drop = (live_cnt > cnt_q) ? (live_cnt - cnt_q) : '0;
      for (int i = 0; i < NUM_SM; i++) begin
         rank_add[i]  = CNT_W'($countones(cand_add & ahead_q[i]));
         rank_drop[i] = CNT_W'($countones(live_ins & behind[i]));
         add_sel[i]   = cand_add[i] && (rank_add[i] < need_add);
         drop_sel[i]  = live_ins[i] && (rank_drop[i] < need_drop);
      end
      ins_d = (live_ins | add_sel) & ~drop_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ins_q <= '0;
         err_o <= 1'b0;
      end else begin
         ins_q <= ins_d;
         err_o <= err_q;
      end
   end

   // R2: the inserted count follows the clamped request one edge later
   a_r2_count_met: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ins_q) == $countones($past(cnt_q)) + 0 || 32'($countones(ins_q)) == 32'($past(cnt_q)));

   // R3: a rising request never removes an inserted submodule
   a_r3_keep_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > $past(cnt_q) && fault_q == '0) |=> ((ins_q & $past(ins_q)) == $past(ins_q)));

   // R6: unchanged request and no faults hold the selection
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == $past(cnt_q) && fault_q == '0) |=> $stable(ins_q));

   // R8: a flagged submodule is out of the set
   a_r8_fault_out: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_q & $past(fault_q)) == '0);

endmodule

// File: rtl/sm_balance_top.sv
module sm_balance_top #(
   parameter int NUM_SM = 8,
   parameter int CUR_W  = 12,
   parameter int CNT_W  = $clog2(NUM_SM + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        req_cnt,
   input  logic [NUM_SM*CUR_W-1:0] sm_cur,
   input  logic                    arm_vpos,
   input  logic [NUM_SM-1:0]       sm_fault,
   output logic [NUM_SM-1:0]       gate_hi,
   output logic [NUM_SM-1:0]       gate_lo,
   output logic                    clamp_err
);

   if (NUM_SM < 2) begin : g_bad_num
      $error("sm_balance_top: NUM_SM must be at least 2");
   end
   if (CUR_W < 2 || CUR_W > 32) begin : g_bad_cur
      $error("sm_balance_top: CUR_W must lie in 2..32");
   end
   if (CNT_W < $clog2(NUM_SM + 1)) begin : g_bad_cnt
      $error("sm_balance_top: CNT_W too narrow for NUM_SM");
   end

   logic [NUM_SM-1:0][NUM_SM-1:0] ahead_q;
   logic [CNT_W-1:0]              cnt_q;
   logic [NUM_SM-1:0]             fault_q;
   logic                          err_q;
   logic [NUM_SM-1:0]             ins_q;

   sm_rank_stage #(.NUM_SM(NUM_SM), .CUR_W(CUR_W), .CNT_W(CNT_W)) rank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_cnt  (req_cnt),
      .sm_cur   (sm_cur),
      .arm_vpos (arm_vpos),
      .sm_fault (sm_fault),
      .ahead_q  (ahead_q),
      .cnt_q    (cnt_q),
      .fault_q  (fault_q),
      .err_q    (err_q)
   );

   sm_select_stage #(.NUM_SM(NUM_SM), .CNT_W(CNT_W)) sel_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ahead_q (ahead_q),
      .cnt_q   (cnt_q),
      .fault_q (fault_q),
      .err_q   (err_q),
      .ins_q   (ins_q),
      .err_o   (clamp_err)
   );

   assign gate_hi = ins_q;
   assign gate_lo = ~ins_q;

   // R1: leaving reset, the arm starts fully bypassed
   a_r1_reset_bypass: assert property (@(posedge clk)
      $rose(rst_n) |-> (gate_hi == '0 && clamp_err == 1'b0));

   // R9: the flag only appears when every healthy submodule is inserted
   a_r9_err_full: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_err |-> ((gate_hi | $past(fault_q)) == '1));

endmodule

// File: tb/sm_balance_top_tb_top.sv
module sm_balance_top_tb_top;

   localparam int N  = 8;
   localparam int CW = 12;
   localparam int KW = $clog2(N + 1);

   typedef struct {
      int          due;
      logic [N-1:0] hi;
      logic        err;
      string       tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [KW-1:0]   req_cnt = '0;
   logic [N*CW-1:0] sm_cur = '0;
   logic            arm_vpos = 1'b1;
   logic [N-1:0]    sm_fault = '0;
   logic [N-1:0]    gate_hi, gate_lo;
   logic            clamp_err;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;
   exp_t sb_q[$];

   always #4ns clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sm_balance_top #(.NUM_SM(N), .CUR_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_cnt(req_cnt), .sm_cur(sm_cur),
      .arm_vpos(arm_vpos), .sm_fault(sm_fault),
      .gate_hi(gate_hi), .gate_lo(gate_lo), .clamp_err(clamp_err)
   );

   function automatic logic [N*CW-1:0] pack8(input int c0, c1, c2, c3, c4, c5, c6, c7);
      logic [N*CW-1:0] v;
      int a[8];
      a = '{c0, c1, c2, c3, c4, c5, c6, c7};
      for (int i = 0; i < N; i++) v[i*CW +: CW] = CW'(a[i]);
      return v;
   endfunction

   task automatic check_now(input logic [N-1:0] ehi, input logic eerr, input string tag);
      checks++;
      if (gate_hi !== ehi) begin
         errors++;
         $display("FAIL %s gate_hi actual %h expected %h", tag, gate_hi, ehi);
      end
      checks++;
      if (gate_lo !== ~ehi) begin
         errors++;
         $display("FAIL R10 (%s) gate_lo actual %h expected %h", tag, gate_lo, ~ehi);
      end
      checks++;
      if (clamp_err !== eerr) begin
         errors++;
         $display("FAIL %s clamp_err actual %b expected %b", tag, clamp_err, eerr);
      end
   endtask

   // driver: called at a falling edge; result due two rising edges later
   task automatic step(input int req, input logic vpos, input logic [N-1:0] flt,
                       input logic [N*CW-1:0] cur, input logic [N-1:0] ehi,
                       input logic eerr, input string tag);
      exp_t e;
      req_cnt  = KW'(req);
      arm_vpos = vpos;
      sm_fault = flt;
      sm_cur   = cur;
      e.due = cyc + 2;
      e.hi  = ehi;
      e.err = eerr;
      e.tag = tag;
      sb_q.push_back(e);
      repeat (2) @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
         exp_t e;
         e = sb_q.pop_front();
         check_now(e.hi, e.err, e.tag);
      end
   end

   initial begin
      logic [N*CW-1:0] ramp_up, ramp_dn, flat;
      ramp_up = pack8(500, 100, 300, 700, 200, 600, 400, 800);
      ramp_dn = pack8(800, 700, 600, 500, 400, 300, 200, 100);
      flat    = pack8(250, 250, 250, 250, 250, 250, 250, 250);
      repeat (3) @(negedge clk);
      check_now(8'h00, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check_now(8'h00, 1'b0, "R1 after reset");
      // R2 R3: positive arm, three lowest currents (1,4,2)
      step(3, 1'b1, 8'h00, ramp_up, 8'h16, 1'b0, "R2 R3 first insert");
      // R6: currents reordered, same count -> held
      step(3, 1'b1, 8'h00, ramp_dn, 8'h16, 1'b0, "R6 hold");
      // R3: +2 -> lowest bypassed are 7 and 6
      step(5, 1'b1, 8'h00, ramp_dn, 8'hD6, 1'b0, "R3 rise");
      // R5: -3 -> highest inserted 1,2,4 leave
      step(2, 1'b1, 8'h00, ramp_dn, 8'hC0, 1'b0, "R5 fall pos");
      // R4: negative arm, +2 -> highest bypassed 0,1
      step(4, 1'b0, 8'h00, ramp_dn, 8'hC3, 1'b0, "R4 rise neg");
      // R5: negative arm, -1 -> lowest inserted 7 leaves
      step(3, 1'b0, 8'h00, ramp_dn, 8'h43, 1'b0, "R5 fall neg");
      // R7: equal currents, +2 -> lowest indices 2,3
      step(5, 1'b1, 8'h00, flat, 8'h4F, 1'b0, "R7 tie insert");
      // R7: equal currents, -1 -> highest index 6 leaves
      step(4, 1'b1, 8'h00, flat, 8'h0F, 1'b0, "R7 tie bypass");
      // R8: submodule 1 faults, spare 4 (lowest current) replaces it
      step(4, 1'b1, 8'h02, pack8(250, 250, 250, 250, 100, 250, 250, 250), 8'h1D, 1'b0, "R8 fault spare");
      // R9: request 8 with 7 healthy -> clamp, flag
      step(8, 1'b1, 8'h02, flat, 8'hFD, 1'b1, "R9 clamp");
      // R9: request 7 -> flag clears, set held
      step(7, 1'b1, 8'h02, flat, 8'hFD, 1'b0, "R9 flag clear");
      // R6: fault released with same count -> held, 1 stays bypassed
      step(7, 1'b1, 8'h00, flat, 8'hFD, 1'b0, "R6 hold after fault");
      // R2: request zero -> all bypassed
      step(0, 1'b0, 8'h00, flat, 8'h00, 1'b0, "R2 zero");
      repeat (2) @(negedge clk);
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL R2 scoreboard left %0d pending items, expected 0", sb_q.size());
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog expired actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule